// File: doc/BRIEF.md
# Watchdog Timer with Keyed Start and Stop

This block is a free-running upward counter. If software lets it run past its all-ones value, it raises a reset request. The counter advances only on a slow timebase strobe, `tick_i`, which stands for the edges of a 32 kHz clock sampled in the bus clock. Software changes the block's settings through a simple write/read register port. Each write is posted: the word is held in a per-register holding slot and sets that slot's pending bit. The word takes effect on the next slow tick, and that tick clears the pending bit.

Starting and stopping the counter both need a two-word key written to the sequence register, one word after the other. Software keeps the watchdog alive by writing a trigger word that differs from the last accepted one. Each such write reloads the counter from the load register. While the counter runs, the divider and load settings are frozen, so a stray write cannot lengthen the timeout. An optional power-of-two divider slows the count rate.

Top module: `wdt_timer`

Register addresses: 0 divider control, 1 load, 2 trigger, 3 sequence key, 4 pending status, 5 counter value, 6 run state. Reads of addresses 3 and 7 return zero.

## Requirements
- R1: After reset, every register, the counter, the status word and the run state read zero, and `wdt_rst_o` is low.
- R2: A write to register 0, 1, 2 or 3 sets the status bit whose index equals that address, from the next clock on. The first `tick_i` after that write commits the posted word and clears the bit. With nothing posted, the status reads zero.
- R3: A pending bit stays set for as long as no `tick_i` arrives.
- R4: Writing 0xAAAA and then 0x5555 to register 3, each committed by a tick, stops the counter. Run state reads 0 after the tick that commits the second word.
- R5: Writing 0xBBBB and then 0x4444 to register 3, each committed by a tick, starts the counter. Run state reads 1 after the tick that commits the second word.
- R6: If the word committed after a first key word is not its partner, the detector returns to idle and the run state does not change. A later partner word alone then has no effect.
- R7: While the counter runs, committed writes to the control register (0) and the load register (1) are discarded, and those registers read back their earlier values.
- R8: With the divider off (control bit 0 clear), a running counter advances by one on every tick. A stopped counter holds its value.
- R9: With control bit 0 set, a running counter advances once every 2^P ticks, where P is control bits 3:1. The divider restarts from zero whenever the counter is stopped or reloaded.
- R10: A committed trigger word that differs from the stored trigger value is stored and reloads the counter from the load register. This happens whether or not the counter runs. A committed trigger equal to the stored value changes nothing.
- R11: When a running counter steps from all ones, it reloads from the load register and `wdt_rst_o` goes high. The output stays high until the next tick, which drops it.
- R12: Several writes to one register before a tick post only the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe per slow timebase edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| wdt_rst_o | output | 1 | Reset request, held for one tick period after rollover |

## Verification
The bench targets the cases a posted design most easily gets wrong:
- **Overwritten posted words.** Two writes land before a tick. A design that latched the first word would commit a stale value.
- **Broken key sequences.** A mismatched second word, or a second first word, must abort the sequence. A detector that stayed armed would start or stop on the next stray partner word.
- **Repeated trigger value.** A design that reloaded on every trigger write would let a stuck writer keep the watchdog alive.
- **Rollover from all ones.** A wrong reload source or a wrong pulse length shows at the reset output.

Frozen configuration while running and the divider phase after a restart are checked against a tick-by-tick model. The model also runs under seeded random mixes of writes and ticks.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    localparam int REG_ADDR_W = 3;
    localparam int NUM_POSTED = 4;

    // Posted slot indices equal their write addresses
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_LOAD = 1;
    localparam int SLOT_TRIG = 2;
    localparam int SLOT_SEQ  = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_LOAD  = 3'd1,
        REG_TRIG  = 3'd2,
        REG_SEQ   = 3'd3,
        REG_STAT  = 3'd4,
        REG_COUNT = 3'd5,
        REG_RUN   = 3'd6
    } wdt_reg_e;

    localparam logic [15:0] KEY_STOP_FIRST   = 16'hAAAA;
    localparam logic [15:0] KEY_STOP_SECOND  = 16'h5555;
    localparam logic [15:0] KEY_START_FIRST  = 16'hBBBB;
    localparam logic [15:0] KEY_START_SECOND = 16'h4444;

    typedef enum logic [1:0] {
        KEY_IDLE       = 2'd0,
        KEY_HALF_STOP  = 2'd1,
        KEY_HALF_START = 2'd2
    } key_state_e;

endpackage

// File: rtl/wdt_post_regs.sv
`timescale 1ns/1ps
module wdt_post_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 4,
    parameter int ADDR_W = 3
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           tick_i,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              wr_addr_i,
    input  logic [DATA_W-1:0]              wr_data_i,
    output logic [SLOTS-1:0][DATA_W-1:0]   post_data_o,
    output logic [SLOTS-1:0]               pend_o
);

    typedef struct packed {
        logic [SLOTS-1:0]             pend;
        logic [SLOTS-1:0][DATA_W-1:0] data;
    } post_t;

    post_t            post_d, post_q;
    logic [SLOTS-1:0] hit;

    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign hit[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));
    end

    always_comb begin
        post_d = post_q;
        for (int i = 0; i < SLOTS; i++) begin
            // A tick commits the held word; a write in the same cycle stays posted
            if (tick_i) post_d.pend[i] = 1'b0;
            if (hit[i]) begin
                post_d.pend[i] = 1'b1;
                post_d.data[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) post_q <= '0;
        else         post_q <= post_d;
    end

    assign post_data_o = post_q.data;
    assign pend_o      = post_q.pend;

    for (genvar g = 0; g < SLOTS; g++) begin : g_chk
        assert_pend_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            hit[g] |=> post_q.pend[g]);
        assert_pend_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (post_q.pend[g] && tick_i && !hit[g]) |=> !post_q.pend[g]);
        assert_pend_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (post_q.pend[g] && !tick_i) |=> post_q.pend[g]);
        assert_last_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
            hit[g] |=> (post_q.data[g] == $past(wr_data_i)));
    end

endmodule

// File: rtl/wdt_key_det.sv
`timescale 1ns/1ps
module wdt_key_det
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              start_o,
    output logic              stop_o
);

    typedef struct packed {
        key_state_e st;
    } key_t;

    key_t key_d, key_q;

    always_comb begin
        key_d   = key_q;
        start_o = 1'b0;
        stop_o  = 1'b0;
        if (commit_i) begin
            unique case (key_q.st)
                KEY_IDLE: begin
                    if (word_i == DATA_W'(KEY_STOP_FIRST))
                        key_d.st = KEY_HALF_STOP;
                    else if (word_i == DATA_W'(KEY_START_FIRST))
                        key_d.st = KEY_HALF_START;
                end
                KEY_HALF_STOP: begin
                    stop_o   = (word_i == DATA_W'(KEY_STOP_SECOND));
                    key_d.st = KEY_IDLE;
                end
                KEY_HALF_START: begin
                    start_o  = (word_i == DATA_W'(KEY_START_SECOND));
                    key_d.st = KEY_IDLE;
                end
                default: key_d.st = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) key_q <= '{st: KEY_IDLE};
        else         key_q <= key_d;
    end

    assert_key_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && key_q.st != KEY_IDLE) |=> (key_q.st == KEY_IDLE));
    assert_key_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_i |=> $stable(key_q.st));
    assert_key_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(start_o && stop_o));

endmodule

// File: rtl/wdt_prescale.sv
`timescale 1ns/1ps
module wdt_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic [PTV_W-1:0] ptv_i,
    output logic             step_o
);

    localparam int DIV_W = (2 ** PTV_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_t;

    div_t             div_d, div_q;
    logic [DIV_W:0]   pow;
    logic [DIV_W-1:0] term;

    assign pow    = (DIV_W + 1)'(1) << ptv_i;
    assign term   = DIV_W'(pow - (DIV_W + 1)'(1));
    assign step_o = tick_i && !clear_i && (!en_i || (div_q.div == term));

    always_comb begin
        div_d = div_q;
        if (clear_i)      div_d.div = '0;
        else if (step_o)  div_d.div = '0;
        else if (tick_i)  div_d.div = div_q.div + DIV_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    assert_div_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !clear_i) |-> (div_q.div <= term));
    assert_div_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clear_i) |=> $stable(div_q.div));

endmodule

// File: rtl/wdt_timer.sv
`timescale 1ns/1ps
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PTV_W  = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_i,
    input  logic                  wr_en_i,
    input  logic [REG_ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [REG_ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic                  wdt_rst_o
);

    localparam int SLOTS = NUM_POSTED;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] trig;
        logic [DATA_W-1:0] cnt;
        logic              run;
        logic              rst_req;
    } core_t;

    core_t                        core_d, core_q;
    logic [SLOTS-1:0][DATA_W-1:0] post_data;
    logic [SLOTS-1:0]             pend;
    logic [SLOTS-1:0]             commit;
    logic                         start, stop, reload, step;

    wdt_post_regs #(
        .DATA_W (DATA_W),
        .SLOTS  (SLOTS),
        .ADDR_W (REG_ADDR_W)
    ) u_post (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .post_data_o (post_data),
        .pend_o      (pend)
    );

    assign commit = pend & {SLOTS{tick_i}};
    assign reload = commit[SLOT_TRIG] && (post_data[SLOT_TRIG] != core_q.trig);

    wdt_key_det #(
        .DATA_W (DATA_W)
    ) u_key (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .commit_i (commit[SLOT_SEQ]),
        .word_i   (post_data[SLOT_SEQ]),
        .start_o  (start),
        .stop_o   (stop)
    );

    wdt_prescale #(
        .PTV_W (PTV_W)
    ) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .clear_i (!core_q.run || reload),
        .en_i    (core_q.ctrl[0]),
        .ptv_i   (core_q.ctrl[PTV_W:1]),
        .step_o  (step)
    );

    always_comb begin
        core_d = core_q;
        // Configuration commits only while stopped
        if (commit[SLOT_CTRL] && !core_q.run) core_d.ctrl = post_data[SLOT_CTRL];
        if (commit[SLOT_LOAD] && !core_q.run) core_d.load = post_data[SLOT_LOAD];
        if (reload) core_d.trig = post_data[SLOT_TRIG];
        if (start)     core_d.run = 1'b1;
        else if (stop) core_d.run = 1'b0;
        if (tick_i) core_d.rst_req = 1'b0;
        if (reload) begin
            core_d.cnt = core_d.load;
        end else if (step) begin
            if (core_q.cnt == '1) begin
                core_d.cnt     = core_q.load;
                core_d.rst_req = 1'b1;
            end else begin
                core_d.cnt = core_q.cnt + DATA_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) core_q <= '0;
        else         core_q <= core_d;
    end

    always_comb begin
        unique case (wdt_reg_e'(rd_addr_i))
            REG_CTRL:  rd_data_o = core_q.ctrl;
            REG_LOAD:  rd_data_o = core_q.load;
            REG_TRIG:  rd_data_o = core_q.trig;
            REG_STAT:  rd_data_o = DATA_W'(pend);
            REG_COUNT: rd_data_o = core_q.cnt;
            REG_RUN:   rd_data_o = DATA_W'(core_q.run);
            default:   rd_data_o = '0;
        endcase
    end

    assign wdt_rst_o = core_q.rst_req;

    assert_cfg_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_q.run |=> ($stable(core_q.ctrl) && $stable(core_q.load)));
    assert_cnt_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(core_q.cnt));
    assert_stopped_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!core_q.run && !pend[SLOT_TRIG]) |=> $stable(core_q.cnt));
    assert_same_trig_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!core_q.run && commit[SLOT_TRIG] && post_data[SLOT_TRIG] == core_q.trig)
        |=> $stable(core_q.cnt));
    assert_rst_one_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_q.rst_req && tick_i) |=> !core_q.rst_req);
    assert_rst_reload_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_q.rst_req) |-> (core_q.cnt == core_q.load));
    assert_run_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(core_q.run) |-> $past(pend[SLOT_SEQ] && tick_i));

endmodule

// File: tb/wdt_timer_tb.sv
`timescale 1ns/1ps
module wdt_timer_tb;
    import wdt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wdt_rst;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Bench model of the requirements
    logic [31:0] m_post [4];
    bit          m_pend [4];
    logic [31:0] m_ctrl, m_load, m_trig, m_cnt;
    bit          m_run, m_rst;
    int          m_key, m_div;

    always #2.5 clk = ~clk;

    wdt_timer u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wdt_rst_o (wdt_rst)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.2;
        d = rd_data;
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        for (int i = 0; i < 4; i++) s[i] = m_pend[i];
        return s;
    endfunction

    function automatic void model_tick();
        bit          rel = 1'b0;
        bit          ovf = 1'b0;
        bit          go = 1'b0;
        bit          halt = 1'b0;
        logic [31:0] w;
        if (m_pend[0] && !m_run) m_ctrl = m_post[0];
        if (m_pend[1] && !m_run) m_load = m_post[1];
        if (m_pend[2] && m_post[2] != m_trig) begin
            m_trig = m_post[2];
            rel = 1'b1;
        end
        if (m_pend[3]) begin
            w = m_post[3];
            case (m_key)
                0: if (w == 32'hAAAA) m_key = 1; else if (w == 32'hBBBB) m_key = 2;
                1: begin halt = (w == 32'h5555); m_key = 0; end
                default: begin go = (w == 32'h4444); m_key = 0; end
            endcase
        end
        if (rel) begin
            m_cnt = m_load;
            m_div = 0;
        end else if (m_run) begin
            if (!m_ctrl[0] || m_div == (1 << m_ctrl[3:1]) - 1) begin
                m_div = 0;
                if (m_cnt == 32'hFFFF_FFFF) begin
                    m_cnt = m_load;
                    ovf = 1'b1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end else begin
                m_div = m_div + 1;
            end
        end else begin
            m_div = 0;
        end
        if (go) m_run = 1'b1;
        else if (halt) m_run = 1'b0;
        m_rst = ovf;
        for (int i = 0; i < 4; i++) m_pend[i] = 1'b0;
    endfunction

    task automatic check_all(input string ctx);
        logic [31:0] d;
        rd(3'd0, d); chk("R7",  {ctx, " ctrl"},   d, m_ctrl);
        rd(3'd1, d); chk("R7",  {ctx, " load"},   d, m_load);
        rd(3'd2, d); chk("R10", {ctx, " trig"},   d, m_trig);
        rd(3'd4, d); chk("R2",  {ctx, " status"}, d, exp_status());
        rd(3'd5, d); chk("R8",  {ctx, " count"},  d, m_cnt);
        rd(3'd6, d); chk("R5",  {ctx, " run"},    d, {31'b0, m_run});
        chk("R11", {ctx, " wdt_rst"}, {31'b0, wdt_rst}, {31'b0, m_rst});
    endtask

    task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 3'd4) begin
            m_post[a] = d;
            m_pend[a] = 1'b1;
        end
    endtask

    task automatic btick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [31:0] d, input string ctx);
        bwrite(a, d);
        btick();
        check_all(ctx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h1d2c_5a17));
        m_ctrl = '0; m_load = '0; m_trig = '0; m_cnt = '0;
        m_run = 1'b0; m_rst = 1'b0; m_key = 0; m_div = 0;
        for (int i = 0; i < 4; i++) begin m_post[i] = '0; m_pend[i] = 1'b0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");
        chk("R1", "reset wdt_rst", {31'b0, wdt_rst}, 32'h0);

        // R2 and R3: posted write visible as pending, held until a tick
        bwrite(3'd1, 32'h100);
        rd(3'd4, d); chk("R2", "load pending bit", d, 32'h2);
        repeat (4) @(negedge clk);
        rd(3'd4, d); chk("R3", "pending held without tick", d, 32'h2);
        btick();
        check_all("R2 commit");
        rd(3'd4, d); chk("R2", "status clear", d, 32'h0);

        // R12: last posted word wins
        bwrite(3'd1, 32'h5);
        bwrite(3'd1, 32'h7);
        btick();
        rd(3'd1, d); chk("R12", "last write wins", d, 32'h7);

        // R10: changed trigger reloads while stopped
        wr_tick(3'd2, 32'h1, "R10 first trigger");
        rd(3'd5, d); chk("R10", "reload when stopped", d, 32'h7);

        // R6: broken start sequences
        wr_tick(3'd3, 32'hBBBB, "R6 a");
        wr_tick(3'd3, 32'h1234, "R6 b");
        wr_tick(3'd3, 32'h4444, "R6 c");
        rd(3'd6, d); chk("R6", "bad second word", d, 32'h0);
        wr_tick(3'd3, 32'hBBBB, "R6 d");
        wr_tick(3'd3, 32'hAAAA, "R6 e");
        wr_tick(3'd3, 32'h4444, "R6 f");
        rd(3'd6, d); chk("R6", "interleaved first word", d, 32'h0);

        // R5: start
        wr_tick(3'd3, 32'hBBBB, "R5 a");
        wr_tick(3'd3, 32'h4444, "R5 b");
        rd(3'd6, d); chk("R5", "started", d, 32'h1);

        // R8: one step per tick
        for (int i = 0; i < 5; i++) begin btick(); check_all("R8 run"); end
        rd(3'd5, d); chk("R8", "count after five ticks", d, 32'hC);

        // R10: same trigger ignored, different reloads
        wr_tick(3'd2, 32'h1, "R10 same");
        rd(3'd5, d); chk("R10", "same trigger no reload", d, 32'hD);
        wr_tick(3'd2, 32'hFFFF_FFFE, "R10 complement");
        rd(3'd5, d); chk("R10", "complement reloads", d, 32'h7);

        // R7: configuration frozen while running
        wr_tick(3'd0, 32'hF, "R7 ctrl");
        wr_tick(3'd1, 32'h99, "R7 load");
        rd(3'd0, d); chk("R7", "ctrl unchanged", d, 32'h0);
        rd(3'd1, d); chk("R7", "load unchanged", d, 32'h7);

        // R4: stop, then counter holds
        wr_tick(3'd3, 32'hAAAA, "R4 a");
        wr_tick(3'd3, 32'h5555, "R4 b");
        rd(3'd6, d); chk("R4", "stopped", d, 32'h0);
        rd(3'd5, d);
        for (int i = 0; i < 3; i++) btick();
        check_all("R8 stopped");
        chk("R8", "stopped count holds", m_cnt, d);

        // R9: divide by 4
        wr_tick(3'd0, 32'h5, "R9 ctrl");
        wr_tick(3'd2, 32'h22, "R9 reload");
        wr_tick(3'd3, 32'hBBBB, "R9 s1");
        wr_tick(3'd3, 32'h4444, "R9 s2");
        for (int i = 0; i < 9; i++) begin btick(); check_all("R9 div"); end
        rd(3'd5, d); chk("R9", "two steps in nine ticks", d, 32'h9);

        // R11: rollover
        wr_tick(3'd3, 32'hAAAA, "R11 p1");
        wr_tick(3'd3, 32'h5555, "R11 p2");
        wr_tick(3'd0, 32'h0, "R11 ctrl");
        wr_tick(3'd1, 32'hFFFF_FFFE, "R11 load");
        wr_tick(3'd2, 32'h33, "R11 trig");
        wr_tick(3'd3, 32'hBBBB, "R11 s1");
        wr_tick(3'd3, 32'h4444, "R11 s2");
        btick(); check_all("R11 top");
        btick(); check_all("R11 wrap");
        chk("R11", "pulse high", {31'b0, wdt_rst}, 32'h1);
        rd(3'd5, d); chk("R11", "reload on wrap", d, 32'hFFFF_FFFE);
        repeat (3) @(negedge clk);
        chk("R11", "pulse held until tick", {31'b0, wdt_rst}, 32'h1);
        btick();
        chk("R11", "pulse dropped", {31'b0, wdt_rst}, 32'h0);

        // Seeded random mix
        for (int n = 0; n < 400; n++) begin
            int unsigned r = $urandom % 100;
            if (r < 40) begin
                btick();
            end else if (r < 55) begin
                logic [31:0] keys [5];
                keys[0] = 32'hAAAA; keys[1] = 32'h5555; keys[2] = 32'hBBBB;
                keys[3] = 32'h4444; keys[4] = $urandom;
                bwrite(3'd3, keys[$urandom % 5]);
            end else if (r < 65) begin
                bwrite(3'd2, ($urandom % 2 == 0) ? m_trig : ~m_trig);
            end else if (r < 75) begin
                bwrite(3'd1, ($urandom % 2 == 0) ? (32'hFFFF_FF00 | ($urandom % 256))
                                                 : ($urandom % 64));
            end else if (r < 85) begin
                bwrite(3'd0, $urandom % 16);
            end else begin
                int k = 1 + int'($urandom % 8);
                for (int j = 0; j < k; j++) btick();
            end
            check_all("random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule